// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a 256-byte serial EEPROM on a two-wire bus. The system clock samples the bus clock and data levels (`scl_i`, `sda_i`) and detects bus events from them. The block drives a single data-out bit, `sda_o`, where 1 means the line is released. A master opens each transaction with a START and sends a device-select byte. After a write select it sends a word address and then any number of data bytes. After a read select it clocks out bytes from the current address for as long as it acknowledges them.

The word-address pointer survives between transactions. A random read is therefore a select-for-write plus a word address, then a repeated START, then a select-for-read. The pointer wraps from 0xFF to 0x00 on reads and on writes alike.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for a START.
- `ST_DEVSEL`: collecting the select byte.
- `ST_WADDR`: collecting the word address.
- `ST_WRITE`: collecting data bytes.
- `ST_READ`: shifting data out.
- `ST_ACK_OUT`: the slave acknowledges.
- `ST_ACK_IN`: waiting for the master's acknowledge.

Its transitions are:
- START: any state to `ST_DEVSEL`.
- STOP: any state to `ST_IDLE`.
- select accept: `ST_DEVSEL` to `ST_ACK_OUT`.
- select reject: `ST_DEVSEL` to `ST_IDLE`.
- address done, byte stored: `ST_WADDR` or `ST_WRITE` to `ST_ACK_OUT`.
- byte sent: `ST_READ` to `ST_ACK_IN`.
- ack release: `ST_ACK_OUT` or `ST_ACK_IN` to the pending state, which is `ST_WADDR`, `ST_WRITE`, `ST_READ` or `ST_IDLE`.

Top module: `eep_2w_slave`

## Requirements
- R1: A START, meaning `sda_i` falls while `scl_i` stays high, moves the block from any state into select collection with the bit count cleared and `sda_o` = 1. A partly received data byte is discarded and not stored.
- R2: A STOP, meaning `sda_i` rises while `scl_i` stays high, returns the block to idle with `sda_o` = 1 from any state, including the middle of a byte.
- R3: The select byte is taken MSB first, one bit per `scl_i` rising edge. At the falling edge after the eighth bit it is accepted only if bits 7 and 5 are both 1; the other bits are ignored, except bit 0. On a reject the block returns to idle and leaves `sda_o` = 1 through the acknowledge clock.
- R4: In the acknowledge state the block drives `sda_o` = 0 from the `scl_i` rising edge. At the following falling edge it releases `sda_o` and moves to the pending state with the bit count cleared.
- R5: A select with bit 0 = 0 leads to an 8-bit word address (MSB first) that is loaded into the pointer. Each following data byte (MSB first) is stored at the pointer and acknowledged, and the pointer then increments modulo 256, with no limit on byte count.
- R6: A select with bit 0 = 1 returns the byte at the retained pointer. Each bit, MSB first, appears on `sda_o` after an `scl_i` rising edge. The pointer increments modulo 256 after each byte.
- R7: During a read, `sda_i` = 0 on the rising edge of the ninth clock (master acknowledge) loads the next byte, and reading continues after that clock's falling edge, including across 0xFF to 0x00.
- R8: During a read, `sda_i` = 1 on the ninth clock (no acknowledge) makes the block stop driving. `sda_o` stays 1 on later clocks until a START or STOP.
- R9: The pointer is retained across STOP and repeated START, so a pointer-setting write followed by a read returns data from the chosen address.
- R10: Reset puts the block in idle with `sda_o` = 1 and the pointer at 0x00. Stored bytes are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus levels |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level driven by the master |
| sda_o | output | 1 | Data line driven by the block, 1 = released |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, 8-bit bytes and a select mask needing bits 7 and 5. With these values the wrap from 0xFF to 0x00 is reached with three bytes starting at 0xFE, for both stored data and sequential reads. The fixed mask allows directed accept and reject cases with one of the two required bits missing, plus an accepted select whose don't-care bits are set. Aborts by STOP and by repeated START in the middle of a data byte are driven at the bus pins and checked through a later read of the same address.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_WADDR,
        ST_WRITE,
        ST_READ,
        ST_ACK_OUT,
        ST_ACK_IN
    } eep_state_t;

endpackage

// File: rtl/eep_bus_events.sv
// Turns sampled bus levels into one-cycle START, STOP and clock-edge pulses.
module eep_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_q & scl_i & sda_q & ~sda_i;
        stop_o  = scl_q & scl_i & ~sda_q & sda_i;
        rise_o  = ~scl_q & scl_i;
        fall_o  = scl_q & ~scl_i;
    end
endmodule

// File: rtl/eep_store.sv
// Byte array: one synchronous write port, one combinational read port.
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave #(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter logic [DATA_W-1:0] SEL_MASK = 8'hA0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);
    import eep_pkg::*;

    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    logic start, stop, rise, fall;
    eep_state_t state, state_nx, pend;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rdata;
    logic byte_done, sel_ok, mem_we;

    eep_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start),
        .stop_o  (stop),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign byte_done = (cnt == FULL);
    assign sel_ok    = ((sh & SEL_MASK) == SEL_MASK);
    assign mem_we    = fall && (state == ST_WRITE) && byte_done;

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (sh),
        .raddr (addr),
        .rdata (rdata)
    );

    // next-state decode
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_DEVSEL;
        end else if (stop) begin
            state_nx = ST_IDLE;
        end else if (fall) begin
            unique case (state)
                ST_IDLE:    ;
                ST_DEVSEL:  if (byte_done) state_nx = sel_ok ? ST_ACK_OUT : ST_IDLE;
                ST_WADDR:   if (byte_done) state_nx = ST_ACK_OUT;
                ST_WRITE:   if (byte_done) state_nx = ST_ACK_OUT;
                ST_READ:    if (byte_done) state_nx = ST_ACK_IN;
                ST_ACK_OUT: state_nx = pend;
                ST_ACK_IN:  state_nx = pend;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and bus output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sh    <= '0;
            addr  <= '0;
            pend  <= ST_IDLE;
            sda_o <= 1'b1;
        end else if (start) begin
            cnt   <= '0;
            sda_o <= 1'b1;
        end else if (stop) begin
            sda_o <= 1'b1;
        end else if (rise) begin
            unique case (state)
                ST_DEVSEL, ST_WADDR, ST_WRITE: begin
                    if (!byte_done) begin
                        sh  <= {sh[DATA_W-2:0], sda_i};
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (!byte_done) begin
                        sda_o <= sh[DATA_W-1];
                        sh    <= {sh[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_ACK_OUT: sda_o <= 1'b0;
                ST_ACK_IN: begin
                    if (!sda_i) begin
                        pend <= ST_READ;
                        sh   <= rdata;
                    end else begin
                        pend <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end else if (fall) begin
            unique case (state)
                ST_DEVSEL: begin
                    if (byte_done) begin
                        cnt   <= '0;
                        sda_o <= 1'b1;
                        if (sh[0]) begin
                            pend <= ST_READ;
                            sh   <= rdata;
                        end else begin
                            pend <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (byte_done) begin
                        addr  <= sh[ADDR_W-1:0];
                        cnt   <= '0;
                        pend  <= ST_WRITE;
                        sda_o <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (byte_done) begin
                        addr  <= addr + 1'b1;
                        cnt   <= '0;
                        pend  <= ST_WRITE;
                        sda_o <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (byte_done) begin
                        addr  <= addr + 1'b1;
                        cnt   <= '0;
                        sda_o <= 1'b1;
                    end
                end
                ST_ACK_OUT, ST_ACK_IN: begin
                    cnt   <= '0;
                    sda_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_2w_slave_chk.sv
module eep_2w_slave_chk #(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter int               CNT_W    = 4,
    parameter logic [DATA_W-1:0] SEL_MASK = 8'hA0
) (
    input logic                clk,
    input logic                rst_n,
    input eep_pkg::eep_state_t state,
    input logic [CNT_W-1:0]    cnt,
    input logic [DATA_W-1:0]   sh,
    input logic [ADDR_W-1:0]   addr,
    input logic                sda_o,
    input logic                start,
    input logic                stop,
    input logic                fall
);
    import eep_pkg::*;

    AST_START_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_DEVSEL && cnt == '0 && sda_o)); // R1

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && sda_o)); // R2

    AST_SELECT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVSEL && fall && cnt == CNT_W'(DATA_W) && (sh & SEL_MASK) != SEL_MASK)
        |=> state == ST_IDLE); // R3

    AST_DRIVE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_o |-> (state == ST_ACK_OUT || state == ST_READ)); // R4

    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && fall && cnt == CNT_W'(DATA_W))
        |=> addr == ADDR_W'($past(addr) + 1'b1)); // R5

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DATA_W)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> sda_o); // R8
endmodule

bind eep_2w_slave eep_2w_slave_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SEL_MASK (SEL_MASK)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .cnt   (cnt),
    .sh    (sh),
    .addr  (addr),
    .sda_o (sda_o),
    .start (start),
    .stop  (stop),
    .fall  (fall)
);

// File: tb/eep_2w_slave_test.sv
module eep_2w_slave_test;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda   = 1'b1;
    wire  sda_o;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    eep_2w_slave uut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (sda),
        .sda_o (sda_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_start();
        drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
    endtask

    task automatic bus_stop();
        drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            drive(1'b0, b[i]); drive(1'b1, b[i]); drive(1'b0, b[i]);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        acked = (sda_o == 1'b0);
        drive(1'b0, 1'b1);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            drive(1'b0, 1'b1);
            drive(1'b1, 1'b1);
            b[i] = sda_o;
            drive(1'b0, 1'b1);
        end
        drive(1'b0, !master_ack); drive(1'b1, !master_ack); drive(1'b0, !master_ack);
    endtask

    task automatic write_seq(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n);
        bit ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R5 select-write ack", ak, 1);
        send_byte(a, ak);     chk("R5 word address ack", ak, 1);
        if (n > 0) begin send_byte(d0, ak); chk("R4 data ack 0", ak, 1); end
        if (n > 1) begin send_byte(d1, ak); chk("R4 data ack 1", ak, 1); end
        if (n > 2) begin send_byte(d2, ak); chk("R4 data ack 2", ak, 1); end
        bus_stop();
    endtask

    task automatic point_then_read(input logic [7:0] a);
        bit ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R9 select-write ack", ak, 1);
        send_byte(a, ak);     chk("R9 pointer ack", ak, 1);
        bus_start();
        send_byte(8'hA1, ak); chk("R9 select-read ack", ak, 1);
    endtask

    task automatic t_reset();
        chk("R10 reset sda_o released", sda_o, 1);
    endtask

    task automatic t_write_basic();
        write_seq(8'h10, 8'h3C, 8'hA5, 8'h96, 3);
        write_seq(8'h13, 8'h0F, 8'h00, 8'h00, 1);
    endtask

    task automatic t_random_read();
        logic [7:0] b;
        int quiet;
        point_then_read(8'h10);
        recv_byte(1'b1, b); chk("R9 random read byte 0", b, 8'h3C);
        recv_byte(1'b1, b); chk("R7 sequential byte 1", b, 8'hA5);
        recv_byte(1'b0, b); chk("R7 sequential byte 2", b, 8'h96);
        quiet = 1;
        for (int k = 0; k < 9; k++) begin
            drive(1'b0, 1'b1); drive(1'b1, 1'b1);
            if (sda_o !== 1'b1) quiet = 0;
            drive(1'b0, 1'b1);
        end
        chk("R8 released after no-ack", quiet, 1);
        bus_stop();
    endtask

    task automatic t_current_read();
        logic [7:0] b;
        bit ak;
        bus_start();
        send_byte(8'hA1, ak); chk("R6 current read select ack", ak, 1);
        recv_byte(1'b0, b);   chk("R6 current address byte", b, 8'h0F);
        bus_stop();
    endtask

    task automatic t_reject();
        logic [7:0] b;
        bit ak;
        bus_start();
        send_byte(8'h20, ak); chk("R3 reject without bit 7", ak, 0);
        bus_start();
        send_byte(8'h80, ak); chk("R3 reject without bit 5", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hEA, ak); chk("R3 accept with don't-care bits", ak, 1);
        send_byte(8'h30, ak); chk("R3 address after odd select", ak, 1);
        send_byte(8'h77, ak); chk("R3 data after odd select", ak, 1);
        bus_stop();
        point_then_read(8'h30);
        recv_byte(1'b0, b); chk("R3 data stored via odd select", b, 8'h77);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic [7:0] b;
        write_seq(8'hFE, 8'h11, 8'h22, 8'h33, 3);
        point_then_read(8'hFE);
        recv_byte(1'b1, b); chk("R5 byte at 0xFE", b, 8'h11);
        recv_byte(1'b1, b); chk("R7 byte at 0xFF", b, 8'h22);
        recv_byte(1'b0, b); chk("R7 wrap to 0x00", b, 8'h33);
        bus_stop();
    endtask

    task automatic t_abort();
        logic [7:0] b;
        bit ak;
        write_seq(8'h40, 8'h55, 8'h00, 8'h00, 1);
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h40, ak);
        send_bits(8'hC3, 4);
        bus_stop();
        chk("R2 released after mid-byte STOP", sda_o, 1);
        point_then_read(8'h40);
        recv_byte(1'b0, b); chk("R2 partial byte not stored", b, 8'h55);
        bus_stop();
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h40, ak);
        send_bits(8'h0F, 5);
        bus_start();
        send_byte(8'hA1, ak); chk("R1 select after repeated START", ak, 1);
        recv_byte(1'b0, b);   chk("R1 aborted byte not stored", b, 8'h55);
        bus_stop();
    endtask

    task automatic t_reset_pointer();
        logic [7:0] b;
        bit ak;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 sda_o released in reset", sda_o, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_start();
        send_byte(8'hA1, ak); chk("R10 select after reset", ak, 1);
        recv_byte(1'b0, b);   chk("R10 pointer back at 0x00", b, 8'h33);
        bus_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_basic();
        t_random_read();
        t_current_read();
        t_reject();
        t_wrap();
        t_abort();
        t_reset_pointer();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule